// File: doc/BRIEF.md
# RTC Interrupt Flag and Alarm Unit

This block collects the three interrupt sources of a real-time clock: a periodic tick, an alarm and the end of each update cycle. It latches each one as an event flag. It combines the flags with their enables into a summary interrupt flag, and drives an active-low open-drain interrupt request from that summary. The timekeeping logic supplies a periodic strobe and an update-done strobe, together with the current hours, minutes and seconds. The block keeps the enables, the inhibit bit and the square-wave enable in a control byte that the host writes through a write strobe.

The alarm check runs once per update. Each of the three alarm bytes is compared with its time byte. An alarm byte whose two top bits are both 1 is treated as a wildcard and left out of the comparison. This gives an alarm once per day, hour, minute or second, depending on how many bytes are wildcards. A read strobe on the status byte clears every flag and releases the interrupt line. A status bit that enables the 32 kHz output can only be changed while the oscillator-control field holds the value 3'b011.

Top module: `rtc_irq_alarm`

## Requirements
- R1: The status byte is {INTF, PF, AF, UF, 0, K32, 0, 0}, with bit 7 INTF, bit 6 PF, bit 5 AF, bit 4 UF and bit 2 K32. Bits 3, 1 and 0 always read 0.
- R2: A periodic strobe sets PF one cycle later, and PF stays set until a status read.
- R3: An update-done strobe sets UF one cycle later.
- R4: On an update-done strobe, AF sets when every alarm byte that is not a wildcard equals its time byte. An alarm byte is a wildcard when bits 7 and 6 are both 1.
- R5: A mismatch in any alarm byte that is not a wildcard prevents AF. Wildcards in hours only, in hours and minutes, or in all three bytes give hourly, per-minute and per-second alarms.
- R6: INTF sets when (PIE and PF), (AIE and AF) or (UIE and UF) holds. This includes an enable that is written after its flag is already set.
- R7: irq_pull_low is 1 (the line is driven low) exactly while INTF is set. Otherwise it is 0 (high impedance).
- R8: A status read clears INTF, PF, AF and UF and releases the interrupt line.
- R9: An event that arrives in the same cycle as a status read leaves its flag set.
- R10: A control write with bit 7 (the transfer inhibit) at 1 stores UIE as 0. An update then sets UF but raises no interrupt.
- R11: K32 takes the written value only while osc_mode is 3'b011. It reads 0 in the cycle after osc_mode holds any other value.
- R12: Reset clears the control byte, K32 and all flags, and releases the interrupt line.
- R13: The control byte reads back as written: bit 7 inhibit, bit 6 PIE, bit 5 AIE, bit 4 UIE, bit 3 square-wave enable, bits 2 to 0 format bits. The only exception is the rule in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_tick | input | 1 | Periodic event strobe |
| upd_done | input | 1 | Update-cycle-ended strobe, also triggers the alarm compare |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| osc_mode | input | 3 | Oscillator-control field |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| k32_we | input | 1 | K32 status bit write strobe |
| k32_wval | input | 1 | K32 write value |
| stat_rd | input | 1 | Status byte read strobe |
| status_q | output | 8 | Status byte |
| ctl_q | output | 8 | Control byte |
| irq_pull_low | output | 1 | 1 drives the open-drain interrupt line low, 0 releases it |

## Verification
The assertions check the following on every cycle:
- each strobe sets its flag on the next cycle;
- a read with no coincident event empties the flags;
- a read that coincides with a tick keeps PF;
- INTF holds whenever an enabled flag is set;
- UIE can never coexist with the inhibit bit;
- K32 drops whenever osc_mode leaves 3'b011.

Some behaviour is shown only by the bench's scenarios. This covers the alarm rate selection through wildcard combinations, the reset state, the readback of the control byte, and the fact that an inhibited update leaves the interrupt line released.

// File: rtl/rtc_irq_pkg.sv
`timescale 1ns/1ps
package rtc_irq_pkg;
  localparam int BYTE_W = 8;
  // status byte bit positions (decoded by host software)
  localparam int ST_INTF = 7;
  localparam int ST_PF   = 6;
  localparam int ST_AF   = 5;
  localparam int ST_UF   = 4;
  localparam int ST_K32  = 2;
  // control byte bit positions
  localparam int CT_INH  = 7;
  localparam int CT_PIE  = 6;
  localparam int CT_AIE  = 5;
  localparam int CT_UIE  = 4;
  localparam logic [2:0] OSC_K32_MODE = 3'b011;

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } evt_t;

  // an alarm byte with both top bits high takes no part in the compare
  function automatic logic byte_ignored(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1] & b[BYTE_W-2];
  endfunction

  function automatic logic field_ok(input logic [BYTE_W-1:0] cur,
                                    input logic [BYTE_W-1:0] alm);
    return byte_ignored(alm) || (cur == alm);
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic intf,
                                                    input evt_t f,
                                                    input logic k32);
    logic [BYTE_W-1:0] s;
    s          = '0;
    s[ST_INTF] = intf;
    s[ST_PF]   = f.per;
    s[ST_AF]   = f.alm;
    s[ST_UF]   = f.upd;
    s[ST_K32]  = k32;
    return s;
  endfunction
endpackage

// File: rtl/rtc_alarm_cmp.sv
`timescale 1ns/1ps
module rtc_alarm_cmp
  import rtc_irq_pkg::*;
#(
  parameter int N_FIELDS = 3
) (
  input  logic [N_FIELDS*BYTE_W-1:0] cur_flat,
  input  logic [N_FIELDS*BYTE_W-1:0] alm_flat,
  output logic                       hit
);
  logic [N_FIELDS-1:0] field_hit;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    assign field_hit[i] = field_ok(cur_flat[i*BYTE_W +: BYTE_W],
                                   alm_flat[i*BYTE_W +: BYTE_W]);
  end

  assign hit = &field_hit;
endmodule

// File: rtl/rtc_ctl_reg.sv
`timescale 1ns/1ps
module rtc_ctl_reg
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [BYTE_W-1:0] ctl_wdata,
  input  logic [2:0]        osc_mode,
  input  logic              k32_we,
  input  logic              k32_wval,
  output logic [BYTE_W-1:0] ctl_q,
  output evt_t              en_nxt,
  output logic              k32_q
);
  logic [BYTE_W-1:0] ctl_d;
  logic              k32_d;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d = ctl_wdata;
      // inhibiting transfers withdraws the update interrupt enable
      if (ctl_wdata[CT_INH]) ctl_d[CT_UIE] = 1'b0;
    end
    en_nxt.per = ctl_d[CT_PIE];
    en_nxt.alm = ctl_d[CT_AIE];
    en_nxt.upd = ctl_d[CT_UIE];

    if (osc_mode != OSC_K32_MODE) k32_d = 1'b0;
    else if (k32_we)              k32_d = k32_wval;
    else                          k32_d = k32_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      k32_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      k32_q <= k32_d;
    end
  end
endmodule

// File: rtl/rtc_flag_bank.sv
`timescale 1ns/1ps
module rtc_flag_bank
  import rtc_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t evt,
  input  evt_t en_nxt,
  input  logic clr,
  output evt_t flag_q,
  output logic intf_q
);
  evt_t flag_d;
  logic req_now;
  logic intf_d;

  always_comb begin
    // a new event wins over a coincident read
    flag_d.per = (flag_q.per & ~clr) | evt.per;
    flag_d.alm = (flag_q.alm & ~clr) | evt.alm;
    flag_d.upd = (flag_q.upd & ~clr) | evt.upd;
    req_now    = (flag_d.per & en_nxt.per) |
                 (flag_d.alm & en_nxt.alm) |
                 (flag_d.upd & en_nxt.upd);
    intf_d     = (intf_q & ~clr) | req_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      intf_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      intf_q <= intf_d;
    end
  end
endmodule

// File: rtl/rtc_irq_alarm.sv
`timescale 1ns/1ps
module rtc_irq_alarm
  import rtc_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       per_tick,
  input  logic       upd_done,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic [2:0] osc_mode,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       k32_we,
  input  logic       k32_wval,
  input  logic       stat_rd,
  output logic [7:0] status_q,
  output logic [7:0] ctl_q,
  output logic       irq_pull_low
);
  localparam int N_FIELDS = 3;

  evt_t en_nxt;
  evt_t evt;
  evt_t flag_q;
  logic intf_q;
  logic k32_q;
  logic alarm_hit;   // time matches all non-wildcard alarm bytes
  logic alarm_evt;   // compare result taken at an update

  rtc_alarm_cmp #(.N_FIELDS(N_FIELDS)) u_cmp (
    .cur_flat (BYTE_W'(0) | {cur_hour, cur_min, cur_sec}),
    .alm_flat ({alm_hour, alm_min, alm_sec}),
    .hit      (alarm_hit)
  );

  rtc_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .osc_mode  (osc_mode),
    .k32_we    (k32_we),
    .k32_wval  (k32_wval),
    .ctl_q     (ctl_q),
    .en_nxt    (en_nxt),
    .k32_q     (k32_q)
  );

  assign alarm_evt = upd_done & alarm_hit;
  assign evt.per   = per_tick;
  assign evt.alm   = alarm_evt;
  assign evt.upd   = upd_done;

  rtc_flag_bank u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .en_nxt (en_nxt),
    .clr    (stat_rd),
    .flag_q (flag_q),
    .intf_q (intf_q)
  );

  assign status_q     = pack_status(intf_q, flag_q, k32_q);
  assign irq_pull_low = intf_q;
endmodule

// File: rtl/rtc_irq_alarm_chk.sv
`timescale 1ns/1ps
module rtc_irq_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       per_tick,
  input logic       upd_done,
  input logic       stat_rd,
  input logic [2:0] osc_mode,
  input logic [7:0] status_q,
  input logic [7:0] ctl_q,
  input logic       alarm_hit
);
  AST_PF_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |=> status_q[6]); // R2
  AST_UF_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> status_q[4]); // R3
  AST_AF_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && alarm_hit) |=> status_q[5]); // R4
  AST_AF_ONLY_AT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_done && !status_q[5]) |=> !status_q[5]); // R5
  AST_INTF_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_q[6] && status_q[6]) || (ctl_q[5] && status_q[5]) ||
     (ctl_q[4] && status_q[4])) |-> status_q[7]); // R6
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !per_tick && !upd_done) |=> (status_q[7:4] == 4'b0000)); // R8
  AST_EVENT_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && per_tick) |=> status_q[6]); // R9
  AST_NO_UIE_WHEN_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[7] |-> !ctl_q[4]); // R10
  AST_K32_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_mode != 3'b011) |=> !status_q[2]); // R11
endmodule

bind rtc_irq_alarm rtc_irq_alarm_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .per_tick  (per_tick),
  .upd_done  (upd_done),
  .stat_rd   (stat_rd),
  .osc_mode  (osc_mode),
  .status_q  (status_q),
  .ctl_q     (ctl_q),
  .alarm_hit (alarm_hit)
);

// File: tb/sim_rtc_irq_alarm.sv
`timescale 1ns/1ps
module sim_rtc_irq_alarm;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       per_tick = 1'b0, upd_done = 1'b0, stat_rd = 1'b0;
  logic [7:0] cur_sec = 8'h45, cur_min = 8'h30, cur_hour = 8'h12;
  logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
  logic [2:0] osc_mode = 3'b010;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       k32_we = 1'b0, k32_wval = 1'b0;
  wire  [7:0] status_q;
  wire  [7:0] ctl_q;
  wire        irq_pull_low;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] st;
    logic [7:0] ct;
    logic       irq;
    string      req;
  } exp_t;
  exp_t q[$];

  // reference model state
  logic [7:0] m_ctl = 8'h00;
  logic m_pf = 0, m_af = 0, m_uf = 0, m_intf = 0, m_k32 = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_irq_alarm u0 (
    .clk(clk), .rst_n(rst_n), .per_tick(per_tick), .upd_done(upd_done),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
    .osc_mode(osc_mode), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .k32_we(k32_we), .k32_wval(k32_wval), .stat_rd(stat_rd),
    .status_q(status_q), .ctl_q(ctl_q), .irq_pull_low(irq_pull_low)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // alarm matching restated: a byte at C0h or above is a wildcard
  function automatic logic alarm_due();
    logic [7:0] a [3];
    logic [7:0] c [3];
    a[0] = alm_sec; a[1] = alm_min; a[2] = alm_hour;
    c[0] = cur_sec; c[1] = cur_min; c[2] = cur_hour;
    for (int i = 0; i < 3; i++)
      if (a[i] < 8'hC0 && a[i] != c[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_intf, m_pf, m_af, m_uf, 1'b0, m_k32, 2'b00};  // R1 layout
  endfunction

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input string req, input logic prd, input logic upd,
                      input logic rd, input logic cwe, input logic [7:0] cwd,
                      input logic kwe, input logic kwv);
    exp_t e;
    logic hit;
    @(negedge clk);
    per_tick = prd; upd_done = upd; stat_rd = rd;
    ctl_we = cwe; ctl_wdata = cwd; k32_we = kwe; k32_wval = kwv;
    if (cwe) begin
      m_ctl = cwd;
      if (cwd[7]) m_ctl[4] = 1'b0;
    end
    if (osc_mode != 3'b011) m_k32 = 1'b0;
    else if (kwe) m_k32 = kwv;
    hit    = alarm_due();
    m_pf   = (m_pf && !rd) || prd;
    m_af   = (m_af && !rd) || (upd && hit);
    m_uf   = (m_uf && !rd) || upd;
    m_intf = (m_intf && !rd) || (m_ctl[6] && m_pf) ||
             (m_ctl[5] && m_af) || (m_ctl[4] && m_uf);
    e.st = exp_status(); e.ct = m_ctl; e.irq = m_intf; e.req = req;
    q.push_back(e);
    @(posedge clk);
    #1;
    per_tick = 0; upd_done = 0; stat_rd = 0; ctl_we = 0; k32_we = 0;
  endtask

  task automatic idle(input string req);
    step(req, 0, 0, 0, 0, 8'h00, 0, 0);
  endtask
  task automatic rd_stat(input string req);
    step(req, 0, 0, 1, 0, 8'h00, 0, 0);
  endtask
  task automatic wr_ctl(input string req, input logic [7:0] v);
    step(req, 0, 0, 0, 1, v, 0, 0);
  endtask
  task automatic update(input string req);
    step(req, 0, 1, 0, 0, 8'h00, 0, 0);
  endtask

  // monitor: compares outputs a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "status", status_q, e.st);
        chk(e.req, "control", ctl_q, e.ct);
        chk(e.req, "irq", {7'b0, irq_pull_low}, {7'b0, e.irq});
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (2) @(negedge clk);
    chk("R12", "status in reset", status_q, 8'h00);
    chk("R12", "control in reset", ctl_q, 8'h00);
    chk("R12", "irq in reset", {7'b0, irq_pull_low}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    idle("R1 idle");
    step("R2 tick sets PF", 1, 0, 0, 0, 8'h00, 0, 0);
    idle("R2 PF held, R7 irq released while PIE=0");
    wr_ctl("R6 late PIE raises INTF, R13", 8'h40);
    idle("R7 irq held low");
    rd_stat("R8 read clears");
    step("R9 tick with read keeps PF", 1, 0, 1, 0, 8'h00, 0, 0);
    rd_stat("R8 read clears again");
    wr_ctl("R13 control readback", 8'h3D);

    // alarm: exact match on all three
    alm_hour = 8'h12; alm_min = 8'h30; alm_sec = 8'h45;
    update("R3 R4 exact alarm match");
    rd_stat("R8");
    alm_sec = 8'h44;
    update("R5 seconds mismatch blocks AF");
    rd_stat("R8");
    alm_hour = 8'hC0; alm_sec = 8'h45; cur_hour = 8'h07;
    update("R4 hourly alarm, hour wildcard");
    rd_stat("R8");
    alm_min = 8'hFF; alm_sec = 8'hC3; cur_min = 8'h01; cur_sec = 8'h59;
    update("R5 per-second alarm, all wildcards");
    rd_stat("R8");
    alm_sec = 8'h10;
    update("R5 per-minute alarm misses on seconds");
    cur_sec = 8'h10;
    update("R5 per-minute alarm hits on seconds");
    rd_stat("R8");
    alm_hour = 8'h87; cur_hour = 8'h87; alm_min = 8'h01; alm_sec = 8'h10;
    update("R4 PM hour bit is not a wildcard");
    rd_stat("R8");

    // inhibit withdraws the update interrupt
    wr_ctl("R10 inhibit clears UIE", 8'h90);
    alm_sec = 8'h22;
    update("R10 update without interrupt");
    idle("R10 irq stays released");
    rd_stat("R8");
    wr_ctl("R13 UIE without inhibit", 8'h10);
    update("R6 UF with UIE raises INTF");
    rd_stat("R8 irq released");

    // K32 write gating
    step("R11 write ignored outside 011", 0, 0, 0, 0, 8'h00, 1, 1);
    osc_mode = 3'b011;
    step("R11 write taken at 011", 0, 0, 0, 0, 8'h00, 1, 1);
    idle("R11 K32 held");
    step("R11 write 0 at 011", 0, 0, 0, 0, 8'h00, 1, 0);
    step("R11 write 1 at 011", 0, 0, 0, 0, 8'h00, 1, 1);
    osc_mode = 3'b110;
    idle("R11 K32 cleared by other mode");

    // reset in mid-run
    osc_mode = 3'b011;
    step("R11 set K32", 1, 1, 0, 1, 8'h7F, 1, 1);
    @(negedge clk);
    rst_n = 1'b0;
    m_ctl = 8'h00; m_pf = 0; m_af = 0; m_uf = 0; m_intf = 0; m_k32 = 0;
    #1;
    chk("R12", "status after reset", status_q, 8'h00);
    chk("R12", "control after reset", ctl_q, 8'h00);
    chk("R12", "irq after reset", {7'b0, irq_pull_low}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    idle("R12 still clear after release");

    repeat (2) @(posedge clk);
    #(CLK_P/2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule